// File: doc/BRIEF.md
# Dual Clock Period Comparator

This block takes two free-running clocks, P and Q, that share no phase relation with each other or with the system clock. It works out which of the two has the longer period. Both inputs are expected to run at about the same rate with even high and low times, and far slower than the system clock. Each input is brought into the system clock domain and its rising edges are found there. The system clock cycles between one rising edge and the next are counted, and the count of each finished period is kept.

When both channels have produced a new period count since the last compare, the two counts are compared. Three registered flags then report equal, P shorter, or P longer. The flags hold their value between compares. They stay low from reset until the first compare has been made.

The counter width is a parameter. A period longer than the counter can hold is recorded as the full-scale value.

Top module: `clk_period_cmp`

## Requirements
- R1: After reset all three flags are low, and they stay low until both channels have each measured one full period, from rising edge to rising edge.
- R2: When the two latest period counts are equal, `p_eq_q` is high and the other two flags are low.
- R3: When P's latest period count is smaller than Q's, `p_lt_q` is high and the other two flags are low.
- R4: When P's latest period count is larger than Q's, `p_gt_q` is high and the other two flags are low.
- R5: No more than one flag is ever high. Once any flag has gone high, exactly one flag is high until the next reset.
- R6: The period counters saturate at 2^CNT_W-1 and never wrap. Two periods that are both at or above that value compare as equal.
- R7: The flags change only in the cycle after both channels hold a new period count. If one channel stops toggling, the flags keep their last value, whatever the other channel does.
- R8: A period is measured in system clock cycles. An input that toggles every N system cycles gives a count of 2N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than P and Q |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| p_clk_in | input | 1 | Asynchronous clock P |
| q_clk_in | input | 1 | Asynchronous clock Q |
| p_eq_q | output | 1 | High when the periods of P and Q are equal |
| p_lt_q | output | 1 | High when P's period is shorter than Q's |
| p_gt_q | output | 1 | High when P's period is longer than Q's |

## Verification
The bench builds the block with CNT_W set to 6, so the counter saturates at 63 cycles. With that setting, periods of 60 to 90 system cycles can reach the saturated compare, including the case where one count saturates and the other does not, without long runs. The input half-periods run from 2 to 45 system cycles. This covers input rates just slow enough for the two-flop synchronizers, as well as rates where the counts differ by a single cycle.

// File: rtl/clk_period_cmp.sv
module clk_period_cmp #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p_clk_in,
  input  logic q_clk_in,
  output logic p_eq_q,
  output logic p_lt_q,
  output logic p_gt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [1:0] sync1, sync2, sync3, rise, armed, fresh;
  logic [CNT_W-1:0] cnt [2];
  logic [CNT_W-1:0] last [2];
  logic take;

  assign rise = sync2 & ~sync3;
  assign take = fresh[0] & fresh[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
      armed <= '0;
      fresh <= '0;
      for (int i = 0; i < 2; i++) begin
        cnt[i]  <= '0;
        last[i] <= '0;
      end
    end else begin
      sync1 <= {q_clk_in, p_clk_in};
      sync2 <= sync1;
      sync3 <= sync2;
      for (int i = 0; i < 2; i++) begin
        if (rise[i]) begin
          cnt[i]   <= CNT_ONE;
          armed[i] <= 1'b1;
          if (armed[i]) begin
            last[i]  <= cnt[i];
            fresh[i] <= 1'b1;
          end else if (take) begin
            fresh[i] <= 1'b0;
          end
        end else begin
          if (cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + CNT_ONE;
          if (take) fresh[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_eq_q <= 1'b0;
      p_lt_q <= 1'b0;
      p_gt_q <= 1'b0;
    end else if (take) begin
      p_eq_q <= last[0] == last[1];
      p_lt_q <= last[0] <  last[1];
      p_gt_q <= last[0] >  last[1];
    end
  end
endmodule

module clk_period_cmp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       flags,
  input logic             take,
  input logic             rise_p,
  input logic [CNT_W-1:0] cnt_p,
  input logic [CNT_W-1:0] last_p,
  input logic [CNT_W-1:0] last_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_onehot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 3'b000) |=> ($countones(flags) == 1));

  assert_first_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags != 3'b000) |-> $past(take));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(flags));

  assert_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flags[0] == ($past(last_p) == $past(last_q))));

  assert_less_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flags[1] == ($past(last_p) < $past(last_q))));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_p == CNT_MAX && !rise_p) |=> (cnt_p == CNT_MAX));
endmodule

bind clk_period_cmp clk_period_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .flags  ({p_gt_q, p_lt_q, p_eq_q}),
  .take   (take),
  .rise_p (rise[0]),
  .cnt_p  (cnt[0]),
  .last_p (last[0]),
  .last_q (last[1])
);

// File: tb/test_clk_period_cmp.sv
`timescale 1ns/1ps
module test_clk_period_cmp;
  localparam int W = 6;
  localparam int SAT = (1 << W) - 1;
  localparam int NV = 10;
  // half-period P, half-period Q (system cycles), expected: 0 eq, 1 lt, 2 gt
  localparam int VEC [NV][3] = '{
    '{5, 5, 0}, '{4, 6, 1}, '{9, 7, 2}, '{20, 21, 1}, '{15, 15, 0},
    '{40, 45, 0}, '{30, 33, 1}, '{33, 30, 2}, '{3, 3, 0}, '{2, 3, 1}};

  logic clk = 0, rst_n = 0, p = 0, q = 0;
  logic eq, lt, gt;
  int hp = 0, hq = 0, pc = 0, qc = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  clk_period_cmp #(.CNT_W(W)) i_clk_period_cmp (
    .clk(clk), .rst_n(rst_n), .p_clk_in(p), .q_clk_in(q),
    .p_eq_q(eq), .p_lt_q(lt), .p_gt_q(gt));

  always @(negedge clk) begin
    if (hp != 0) begin
      if (pc >= hp - 1) begin p = ~p; pc = 0; end else pc = pc + 1;
    end
    if (hq != 0) begin
      if (qc >= hq - 1) begin q = ~q; qc = 0; end else qc = qc + 1;
    end
  end

  task automatic check(input string req, input logic [2:0] exp);
    total++;
    if ({gt, lt, eq} !== exp) begin
      bad++;
      $display("FAIL %s: flags gt,lt,eq=%b expected %b", req, {gt, lt, eq}, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] code(input int c);
    return (c == 0) ? 3'b001 : (c == 1) ? 3'b010 : 3'b100;
  endfunction

  initial begin
    #900us;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(4);
    check("R1 reset", 3'b000);
    rst_n = 1;
    wait_cyc(50);
    check("R1 no edges", 3'b000);
    hp = 5;
    wait_cyc(300);
    check("R1 only P running", 3'b000);

    for (int v = 0; v < NV; v++) begin
      int mx, pp, qq, e;
      hp = VEC[v][0];
      hq = VEC[v][1];
      mx = (hp > hq) ? hp : hq;
      wait_cyc(16 * mx + 40);
      pp = (2 * hp > SAT) ? SAT : 2 * hp;
      qq = (2 * hq > SAT) ? SAT : 2 * hq;
      e = (pp == qq) ? 0 : (pp < qq) ? 1 : 2;
      if (e != VEC[v][2]) $display("table entry %0d inconsistent", v);
      case (e)
        0: check((pp == SAT) ? "R6 both saturated" : "R2 R8 equal", code(e));
        1: check((qq == SAT) ? "R6 one saturated lt" : "R3 R8 shorter", code(e));
        default: check("R4 R8 longer", code(e));
      endcase
    end

    hp = 10; hq = 10;
    wait_cyc(400);
    check("R2 before freeze", 3'b001);
    hq = 0;
    wait_cyc(200);
    check("R7 Q frozen", 3'b001);
    hp = 4;
    wait_cyc(400);
    check("R7 P changed, Q frozen", 3'b001);
    hp = 30;
    wait_cyc(600);
    check("R7 P slowed, Q frozen", 3'b001);

    rst_n = 0;
    wait_cyc(3);
    check("R1 mid-run reset", 3'b000);
    rst_n = 1;
    hp = 6; hq = 0;
    wait_cyc(200);
    check("R1 after reset, Q idle", 3'b000);
    hq = 8;
    wait_cyc(300);
    check("R3 R5 after restart", 3'b010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule